// File: doc/BRIEF.md
# Resource Recovery Timeout Timer

This block measures the sequence-initiative resource recovery timeout. A controller programs it with a 3-bit units code and an 8-bit count, then pulses a start input. The block captures both values at that moment. It picks a time base of 1 ms, 0.1 s or 10 s from the units code, and counts the programmed number of those units. When the time is up it raises a one-cycle expiry pulse. A running status output is high for the whole time the timer is armed.

The time base comes from one prescaler. The prescaler's terminal counts are derived from a clock-frequency parameter, so the same block works at any system clock that is a whole multiple of 1 kHz. A units code of zero means no timer is specified. Zero and every reserved code make the block ignore the count and use a default duration instead. The default duration is a parameter given in milliseconds. The action taken after expiry belongs to the surrounding logic.

Top module: `rrt_timer`

## Requirements
- R1: While reset is asserted and after it is released with no start, running_o and expired_o are both 0.
- R2: With units code 3'b001 and count N >= 1, expired_o is 1 exactly N*CLK_HZ/1000 clock edges after the edge that captured start_i. running_o is 1 from the edge after that capture until the expiry edge.
- R3: With units code 3'b011 and count N >= 1, expiry comes N*CLK_HZ/10 edges after the capture edge.
- R4: With units code 3'b101 and count N >= 1, expiry comes N*CLK_HZ*10 edges after the capture edge.
- R5: With units code 3'b000, 3'b010, 3'b100, 3'b110 or 3'b111, the count is ignored. Expiry comes DEFAULT_MS*CLK_HZ/1000 edges after the capture edge.
- R6: A count of 0 with a valid units code (001, 011, 101) expires after one unit of that code.
- R7: expired_o is high for exactly one cycle, and running_o falls at the same edge at which expired_o rises.
- R8: A start while the timer runs reloads the captured code and count and restarts timing from the new capture edge. The earlier run never expires.
- R9: A cancel without start stops the timer at the next edge with no expiry pulse. When start and cancel are sampled together, start wins. A cancel while idle has no effect.
- R10: The units code and count are sampled only at start. Changing them while the timer runs does not alter its expiry time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture code and count, then (re)arm the timer |
| cancel_i | input | 1 | Stop the timer without an expiry pulse |
| units_i | input | 3 | Units code: 001 = 1 ms, 011 = 0.1 s, 101 = 10 s, others use the default |
| count_i | input | COUNT_W | Number of units to time |
| expired_o | output | 1 | One-cycle pulse when the programmed time has elapsed |
| running_o | output | 1 | High while the timer is armed |

## Verification
The bound checker checks the following on every cycle:
- the expiry pulse lasts one cycle and coincides with running falling;
- an expiry always follows a unit tick;
- ticks only occur while armed;
- start arms the timer without a pulse;
- a lone cancel disarms it silently;
- the captured unit stays frozen during a run;
- the remaining count changes only on ticks or start.

Only the bench's scenarios can show the exact expiry cycle for each units code, the default fallback for reserved codes, the one-unit behaviour of a zero count, and that a restart discards the earlier deadline. Those properties are durations measured in cycles from a start, not relations between neighbouring cycles.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  // Time base selected for a run.
  typedef enum logic [1:0] {
    UNIT_1MS   = 2'd0,
    UNIT_100MS = 2'd1,
    UNIT_10S   = 2'd2
  } unit_e;

  typedef struct packed {
    logic  use_default;
    unit_e unit;
  } units_dec_t;

  localparam int unsigned CODE_W  = 3;
  localparam int unsigned N_UNITS = 3;

  // Sparse units code decode; anything not explicitly valid uses the default.
  function automatic units_dec_t decode_units(input logic [CODE_W-1:0] code);
    units_dec_t d;
    d.use_default = 1'b0;
    d.unit        = UNIT_1MS;
    case (code)
      3'b001:  d.unit = UNIT_1MS;
      3'b011:  d.unit = UNIT_100MS;
      3'b101:  d.unit = UNIT_10S;
      default: d.use_default = 1'b1;
    endcase
    return d;
  endfunction

  // Clock cycles in one unit for a given clock frequency.
  function automatic int unsigned unit_cycles(input unit_e u, input int unsigned clk_hz);
    case (u)
      UNIT_1MS:   return clk_hz / 1000;
      UNIT_100MS: return clk_hz / 10;
      default:    return clk_hz * 10;
    endcase
  endfunction

endpackage

// File: rtl/rrt_cfg_capture.sv
module rrt_cfg_capture
  import rrt_pkg::*;
#(
  parameter int unsigned COUNT_W    = 8,
  parameter int unsigned REM_W      = 16,
  parameter int unsigned DEFAULT_MS = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CODE_W-1:0]  code,
  input  logic [COUNT_W-1:0] count,
  output unit_e              unit_q,
  output logic [REM_W-1:0]   load_val
);

  units_dec_t dec;

  always_comb begin
    dec      = decode_units(code);
    load_val = dec.use_default ? REM_W'(DEFAULT_MS) : REM_W'(count);
  end

  // The unit is frozen at start; the default always runs on the 1 ms base.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_q <= UNIT_1MS;
    end else if (start) begin
      unit_q <= dec.use_default ? UNIT_1MS : dec.unit;
    end
  end

endmodule

// File: rtl/rrt_prescaler.sv
module rrt_prescaler
  import rrt_pkg::*;
#(
  parameter int unsigned P_1MS   = 100000,
  parameter int unsigned P_100MS = 10000000,
  parameter int unsigned P_10S   = 1000000000,
  localparam int unsigned PRE_W  = (P_10S > 1) ? $clog2(P_10S) : 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  enable,
  input  unit_e unit,
  output logic  tick
);

  localparam int unsigned PERIOD [N_UNITS] = '{P_1MS, P_100MS, P_10S};

  logic [PRE_W-1:0]   cnt_q;
  logic [N_UNITS-1:0] term;
  logic               term_sel;

  // One terminal-count comparator per unit.
  for (genvar g = 0; g < int'(N_UNITS); g++) begin : g_term
    assign term[g] = (cnt_q == PRE_W'(PERIOD[g] - 1));
  end

  always_comb begin
    case (unit)
      UNIT_1MS:   term_sel = term[0];
      UNIT_100MS: term_sel = term[1];
      default:    term_sel = term[2];
    endcase
  end

  assign tick = enable && !clear && term_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || !enable || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/rrt_unit_counter.sv
module rrt_unit_counter #(
  parameter int unsigned REM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [REM_W-1:0] load_val,
  input  logic             tick,
  output logic             running_q,
  output logic             expired_q,
  output logic [REM_W-1:0] rem_q,
  output logic             expire_evt
);

  // A remaining value of 0 or 1 ends the run on the coming tick.
  logic last_unit;
  assign last_unit  = (rem_q <= REM_W'(1));
  assign expire_evt = running_q && tick && last_unit && !start && !cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      expired_q <= 1'b0;
      rem_q     <= '0;
    end else if (start) begin
      running_q <= 1'b1;
      expired_q <= 1'b0;
      rem_q     <= load_val;
    end else if (cancel) begin
      running_q <= 1'b0;
      expired_q <= 1'b0;
    end else if (expire_evt) begin
      running_q <= 1'b0;
      expired_q <= 1'b1;
    end else begin
      expired_q <= 1'b0;
      if (running_q && tick) begin
        rem_q <= rem_q - REM_W'(1);
      end
    end
  end

endmodule

// File: rtl/rrt_timer.sv
module rrt_timer
  import rrt_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100000000,
  parameter int unsigned COUNT_W    = 8,
  parameter int unsigned REM_W      = 16,
  parameter int unsigned DEFAULT_MS = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               cancel_i,
  input  logic [2:0]         units_i,
  input  logic [COUNT_W-1:0] count_i,
  output logic               expired_o,
  output logic               running_o
);

  localparam int unsigned P_1MS   = unit_cycles(UNIT_1MS, CLK_HZ);
  localparam int unsigned P_100MS = unit_cycles(UNIT_100MS, CLK_HZ);
  localparam int unsigned P_10S   = unit_cycles(UNIT_10S, CLK_HZ);

  unit_e            unit_q;
  logic [REM_W-1:0] load_val;
  logic [REM_W-1:0] rem_q;
  logic             unit_tick;
  logic             expire_evt;
  logic             running_q;
  logic             expired_q;

  rrt_cfg_capture #(
    .COUNT_W    (COUNT_W),
    .REM_W      (REM_W),
    .DEFAULT_MS (DEFAULT_MS)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .code     (units_i),
    .count    (count_i),
    .unit_q   (unit_q),
    .load_val (load_val)
  );

  rrt_prescaler #(
    .P_1MS   (P_1MS),
    .P_100MS (P_100MS),
    .P_10S   (P_10S)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_i),
    .enable (running_q),
    .unit   (unit_q),
    .tick   (unit_tick)
  );

  rrt_unit_counter #(
    .REM_W (REM_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .cancel     (cancel_i),
    .load_val   (load_val),
    .tick       (unit_tick),
    .running_q  (running_q),
    .expired_q  (expired_q),
    .rem_q      (rem_q),
    .expire_evt (expire_evt)
  );

  assign expired_o = expired_q;
  assign running_o = running_q;

endmodule

// File: rtl/rrt_timer_chk.sv
module rrt_timer_chk
  import rrt_pkg::*;
#(
  parameter int unsigned REM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cancel,
  input logic             running,
  input logic             expired,
  input logic             tick,
  input logic             expire_evt,
  input logic [REM_W-1:0] rem,
  input unit_e            unit_q
);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);

  a_r7_fall_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> !running);

  a_r7_pulse_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> expired);

  a_r2_expiry_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(tick));

  a_r2_tick_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> running);

  a_r8_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && !expired));

  a_r9_cancel_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !start) |=> (!running && !expired));

  a_r10_unit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> $stable(unit_q));

  a_r10_rem_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> $stable(rem));

endmodule

bind rrt_timer rrt_timer_chk #(.REM_W(REM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start_i),
  .cancel     (cancel_i),
  .running    (running_o),
  .expired    (expired_o),
  .tick       (unit_tick),
  .expire_evt (expire_evt),
  .rem        (rem_q),
  .unit_q     (unit_q)
);

// File: tb/rrt_timer_tb.sv
`timescale 1ns/1ps
module rrt_timer_tb;

  localparam int unsigned HZ     = 2000;   // 1 ms = 2 cycles, 0.1 s = 200, 10 s = 20000
  localparam int unsigned DEF_MS = 7;      // default = 14 cycles
  localparam int unsigned NV     = 13;

  typedef struct packed {
    logic [2:0]  code;
    logic [7:0]  cnt;
    int unsigned cyc;
    int unsigned req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{3'b001, 8'd5,   32'd10,    32'd2},
    '{3'b001, 8'd1,   32'd2,     32'd2},
    '{3'b001, 8'd255, 32'd510,   32'd2},
    '{3'b011, 8'd2,   32'd400,   32'd3},
    '{3'b011, 8'd1,   32'd200,   32'd3},
    '{3'b101, 8'd1,   32'd20000, 32'd4},
    '{3'b000, 8'd9,   32'd14,    32'd5},
    '{3'b010, 8'd200, 32'd14,    32'd5},
    '{3'b100, 8'd0,   32'd14,    32'd5},
    '{3'b110, 8'd3,   32'd14,    32'd5},
    '{3'b111, 8'd77,  32'd14,    32'd5},
    '{3'b001, 8'd0,   32'd2,     32'd6},
    '{3'b011, 8'd0,   32'd200,   32'd6}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cancel = 1'b0;
  logic [2:0] units = 3'b000;
  logic [7:0] count = 8'd0;
  logic       expired;
  logic       running;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  rrt_timer #(.CLK_HZ(HZ), .DEFAULT_MS(DEF_MS)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .cancel_i  (cancel),
    .units_i   (units),
    .count_i   (count),
    .expired_o (expired),
    .running_o (running)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string req_name(input int unsigned r);
    case (r)
      2:       return "R2";
      3:       return "R3";
      4:       return "R4";
      5:       return "R5";
      default: return "R6";
    endcase
  endfunction

  // Bench's own expectation of the duration in cycles.
  function automatic int unsigned exp_cycles(input logic [2:0] c, input logic [7:0] n);
    int unsigned units_n = (n == 0) ? 1 : int'(n);
    if (c == 3'b001) return units_n * (HZ / 1000);
    if (c == 3'b011) return units_n * (HZ / 10);
    if (c == 3'b101) return units_n * HZ * 10;
    return DEF_MS * HZ / 1000;
  endfunction

  // Called at a negedge; returns at the negedge after the capture edge.
  // Scrambles code and count afterwards to exercise R10.
  task automatic pulse_start(input logic [2:0] c, input logic [7:0] n, input bit with_cancel);
    start  = 1'b1;
    cancel = with_cancel;
    units  = c;
    count  = n;
    @(posedge clk);
    @(negedge clk);
    start  = 1'b0;
    cancel = 1'b0;
    units  = ~c;
    count  = ~n;
  endtask

  task automatic wait_expire(input int unsigned cyc, input string tag);
    bit early = 1'b0;
    for (int unsigned i = 1; i < cyc; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (expired || !running) early = 1'b1;
    end
    chk(!early, tag, "still running with no pulse before deadline", early, 0);
    @(posedge clk);
    @(negedge clk);
    chk(expired == 1'b1, tag, "expired at deadline", expired, 1);
    chk(running == 1'b0, "R7", "running falls with pulse", running, 0);
    @(posedge clk);
    @(negedge clk);
    chk(expired == 1'b0, "R7", "pulse lasts one cycle", expired, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(running == 1'b0, "R1", "running in reset", running, 0);
    chk(expired == 1'b0, "R1", "expired in reset", expired, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(running == 1'b0 && expired == 1'b0, "R1", "idle after reset",
        {running, expired}, 0);

    // Table of vectors (R2..R6, R10 via scrambled inputs)
    for (int v = 0; v < int'(NV); v++) begin
      chk(exp_cycles(VEC[v].code, VEC[v].cnt) == VEC[v].cyc, req_name(VEC[v].req),
          "table duration", exp_cycles(VEC[v].code, VEC[v].cnt), VEC[v].cyc);
      pulse_start(VEC[v].code, VEC[v].cnt, 1'b0);
      chk(running == 1'b1, "R2", "armed after start", running, 1);
      wait_expire(VEC[v].cyc, req_name(VEC[v].req));
      repeat (2) @(negedge clk);
    end

    // R8: restart while running
    pulse_start(3'b001, 8'd10, 1'b0);
    repeat (8) @(posedge clk);
    @(negedge clk);
    pulse_start(3'b001, 8'd3, 1'b0);
    wait_expire(6, "R8");
    begin
      bit seen = 1'b0;
      repeat (30) begin
        @(negedge clk);
        if (expired) seen = 1'b1;
      end
      chk(!seen, "R8", "earlier run never expires", seen, 0);
    end

    // R9: cancel mid-run
    pulse_start(3'b011, 8'd1, 1'b0);
    repeat (50) @(negedge clk);
    cancel = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cancel = 1'b0;
    chk(running == 1'b0, "R9", "cancel stops timer", running, 0);
    begin
      bit seen = 1'b0;
      repeat (300) begin
        @(negedge clk);
        if (expired || running) seen = 1'b1;
      end
      chk(!seen, "R9", "no pulse after cancel", seen, 0);
    end

    // R9: start wins over cancel in the same cycle
    pulse_start(3'b001, 8'd2, 1'b1);
    chk(running == 1'b1, "R9", "start beats cancel", running, 1);
    wait_expire(4, "R9");

    // R9: cancel while idle
    cancel = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cancel = 1'b0;
    chk(running == 1'b0 && expired == 1'b0, "R9", "idle cancel no effect",
        {running, expired}, 0);

    // R10: inputs changed mid-run to a longer setting do not stretch the run
    pulse_start(3'b001, 8'd4, 1'b0);
    units = 3'b101;
    count = 8'd200;
    wait_expire(8, "R10");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule